// File: doc/BRIEF.md
# Tapped Binary Divider with Standby

This block divides a slow oscillator signal through a chain of fourteen binary stages and exports a chosen subset of the stage outputs as divided clocks. The oscillator input is not used as a clock. It is sampled by the system clock through a two-flop synchroniser. Each falling edge that the synchroniser detects advances the fourteen-bit stage count by one. All other oscillator activity leaves the count as it is.

An active-high reset clears every stage. While reset is held, the block also drives its oscillator-enable output low, so the external clock source can be stopped for standby. A programmable terminal-count compare gives a match flag. That flag is raised only while the sampled oscillator level is high, which is the half-period after the count has settled. A consumer of the flag therefore never sees a value taken while the stages are changing.

Top module: `osc_tap_divider`

## Requirements
- R1: The stage count is 14 bits wide. Stage N (numbered from 1) is bit N-1 of the count, so stage N toggles at the oscillator rate divided by 2^N. After 16 counted falls from zero, only stage 5 is set.
- R2: Each falling transition of `osc_in` increments the count by exactly one. The new value is visible on the outputs no later than the third rising `clk` edge after the transition.
- R3: Rising transitions of `osc_in`, and a steady `osc_in` level, leave the count unchanged.
- R4: `rst` is synchronous and active high. At the first rising `clk` edge where `rst` is high, all 14 stages are cleared, and every bit of `taps` reads 0.
- R5: `osc_en` is a register that is 0 while `rst` is high, including from power-up. It returns to 1 at the first edge after `rst` is released.
- R6: `taps` exports ten stages. `taps[6:0]` carry stages 4 through 10 in ascending order, and `taps[9:7]` carry stages 12 through 14. Stages 1, 2, 3 and 11 have no output.
- R7: An oscillator falling transition that happens while `rst` is high is never counted after release. The first increment needs `osc_in` to be sampled high and then low after release.
- R8: `match` is a register. It is 1 only when the full 14-bit count equals `cmp_val` and the synchronised oscillator level is high. While `osc_in` has been low for three or more cycles, `match` is 0.
- R9: The count wraps from 16383 to 0 on the next counted fall, with no pause or extra indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the oscillator |
| rst | input | 1 | Synchronous active-high reset and standby request |
| osc_in | input | 1 | Oscillator signal; its falling edges are counted |
| cmp_val | input | 14 | Terminal-count compare value |
| osc_en | output | 1 | Oscillator enable, low during reset |
| taps | output | 10 | Exported stages 4..10 and 12..14 |
| match | output | 1 | Phase-qualified compare flag |

## Verification
Two events can collide. One is a reset that arrives while an oscillator fall is still travelling through the synchroniser. The other is a new fall that is expected right after release. The bench toggles `osc_in` high and low while `rst` is held, then releases reset with the oscillator both low and high. It then requires the count to stay at zero, or to advance only after a post-release high-to-low sequence. The match flag also meets the increment on every fall: the flag drops before the count changes. The bench judges this by checking `match` against the compare value at the end of each high phase and requiring it low at the end of each low phase.

// File: rtl/osc_div_pkg.sv
package osc_div_pkg;

  // 1-based stage number carried by export position idx (0-based)
  function automatic int tap_stage(input int idx, input int first, input int gap);
    int s;
    s = first + idx;
    if (s >= gap) s = s + 1;
    return s;
  endfunction

  // number of exported stages between first and last, minus the skipped one
  function automatic int tap_count(input int stages, input int first, input int gap);
    int n;
    n = stages - first + 1;
    if (gap >= first && gap <= stages) n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_in,
  output logic level,
  output logic fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= osc_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[LAST-1:0], osc_in};
      end
    end
  endgenerate

  // prev_q starts low after reset, so a fall needs a high sample taken
  // after release
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign level = sync_q[LAST];
  assign fall  = prev_q & ~sync_q[LAST];

endmodule

// File: rtl/stage_counter.sv
module stage_counter #(
  parameter int STAGES = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [STAGES-1:0] cnt
);
  localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + ONE;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tap_select.sv
module tap_select
  import osc_div_pkg::*;
#(
  parameter int STAGES    = 14,
  parameter int FIRST_TAP = 4,
  parameter int GAP_STAGE = 11,
  parameter int NUM_TAPS  = tap_count(STAGES, FIRST_TAP, GAP_STAGE)
) (
  input  logic [STAGES-1:0]   cnt,
  output logic [NUM_TAPS-1:0] taps
);
  generate
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int BITPOS = tap_stage(i, FIRST_TAP, GAP_STAGE) - 1;
      assign taps[i] = cnt[BITPOS];
    end
  endgenerate

endmodule

// File: rtl/match_strobe.sv
module match_strobe #(
  parameter int STAGES = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] cnt,
  input  logic [STAGES-1:0] cmp_val,
  input  logic              phase_hi,
  output logic              match
);
  logic match_q;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= phase_hi && (cnt == cmp_val);
  end

  assign match = match_q;

endmodule

// File: rtl/osc_tap_divider.sv
module osc_tap_divider
  import osc_div_pkg::*;
#(
  parameter int STAGES      = 14,
  parameter int FIRST_TAP   = 4,
  parameter int GAP_STAGE   = 11,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TAPS    = tap_count(STAGES, FIRST_TAP, GAP_STAGE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_in,
  input  logic [STAGES-1:0]   cmp_val,
  output logic                osc_en,
  output logic [NUM_TAPS-1:0] taps,
  output logic                match
);
  logic              osc_level;
  logic              osc_fall;
  logic [STAGES-1:0] cnt_q;
  logic              osc_en_q;

  osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .osc_in (osc_in),
    .level  (osc_level),
    .fall   (osc_fall)
  );

  stage_counter #(.STAGES(STAGES)) u_count (
    .clk  (clk),
    .rst  (rst),
    .step (osc_fall),
    .cnt  (cnt_q)
  );

  tap_select #(
    .STAGES    (STAGES),
    .FIRST_TAP (FIRST_TAP),
    .GAP_STAGE (GAP_STAGE),
    .NUM_TAPS  (NUM_TAPS)
  ) u_taps (
    .cnt  (cnt_q),
    .taps (taps)
  );

  match_strobe #(.STAGES(STAGES)) u_match (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_q),
    .cmp_val  (cmp_val),
    .phase_hi (osc_level),
    .match    (match)
  );

  // standby: oscillator enable held low while reset is applied
  always_ff @(posedge clk) begin
    if (rst) osc_en_q <= 1'b0;
    else     osc_en_q <= 1'b1;
  end

  assign osc_en = osc_en_q;

endmodule

// File: rtl/osc_tap_divider_chk.sv
module osc_tap_divider_chk #(
  parameter int STAGES = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [STAGES-1:0] cnt,
  input logic              fall,
  input logic              level,
  input logic              osc_en,
  input logic              match
);
  localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

  // R2: any change outside reset is a single increment
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cnt != $past(cnt)) |-> cnt == $past(cnt) + ONE);

  // R3: the count moves only after a detected falling edge
  assert_only_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cnt != $past(cnt)) |-> $past(fall));

  // R4: reset clears every stage
  assert_reset_clears_R4: assert property (@(posedge clk)
    $past(rst) |-> cnt == '0);

  // R5: oscillator enable low after reset was sampled
  assert_standby_R5: assert property (@(posedge clk)
    $past(rst) |-> !osc_en);

  // R8: match only follows a high synchronised phase
  assert_match_phase_R8: assert property (@(posedge clk) disable iff (rst)
    match |-> $past(level));

  // R9: all-ones wraps to zero
  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) == '1 && $past(fall)) |-> cnt == '0);

endmodule

bind osc_tap_divider osc_tap_divider_chk #(.STAGES(STAGES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnt    (cnt_q),
  .fall   (osc_fall),
  .level  (osc_level),
  .osc_en (osc_en),
  .match  (match)
);

// File: tb/test_osc_tap_divider.sv
module test_osc_tap_divider;
  localparam int W  = 14;
  localparam int NT = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          osc_in = 1'b0;
  logic [W-1:0]  cmp_val = '0;
  logic          osc_en;
  logic [NT-1:0] taps;
  logic          match;

  int            n_checks = 0;
  int            n_errors = 0;
  int            exp_cnt = 0;
  logic          seen_hi = 1'b0;
  logic          done = 1'b0;

  always #2.5 clk = ~clk;

  osc_tap_divider i_osc_tap_divider (
    .clk     (clk),
    .rst     (rst),
    .osc_in  (osc_in),
    .cmp_val (cmp_val),
    .osc_en  (osc_en),
    .taps    (taps),
    .match   (match)
  );

  // R6 export order: stages 4..10 then 12..14
  function automatic logic [NT-1:0] exp_taps(input int c);
    logic [W-1:0]  v;
    logic [NT-1:0] t;
    v = W'(c);
    for (int i = 0; i < 7; i++) t[i] = v[i+3];
    for (int i = 0; i < 3; i++) t[7+i] = v[11+i];
    return t;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R6 taps"}, 32'(taps), 32'(exp_taps(exp_cnt)));
    check({tag, " R8 match"}, 32'(match),
          32'(osc_in && (W'(exp_cnt) == cmp_val)));
    check({tag, " R5 osc_en"}, 32'(osc_en), 32'(!rst));
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive a level and hold it; model the counted fall
  task automatic drive(input logic lvl, input int hold);
    if (!rst && osc_in && !lvl && seen_hi) exp_cnt = (exp_cnt + 1) % (1 << W);
    osc_in = lvl;
    if (lvl) seen_hi = 1'b1;
    wait_n(hold);
  endtask

  task automatic do_reset(input logic lvl_at_release);
    rst = 1'b1;
    wait_n(4);
    exp_cnt = 0;
    check("R4 reset taps", 32'(taps), 32'h0);
    check("R5 standby osc_en", 32'(osc_en), 32'h0);
    osc_in = lvl_at_release;
    wait_n(3);
    rst = 1'b0;
    seen_hi = 1'b0;
    if (lvl_at_release) seen_hi = 1'b1;
    wait_n(4);
  endtask

  initial begin
    void'($urandom(32'h5eed_0417));
    // power-up reset
    wait_n(5);
    check("R4 reset taps", 32'(taps), 32'h0);
    check("R5 osc_en in reset", 32'(osc_en), 32'h0);
    check("R8 match in reset", 32'(match), 32'h0);

    // R7: falling edge during reset is not counted
    osc_in = 1'b1; wait_n(4);
    osc_in = 1'b0; wait_n(1);
    rst = 1'b0;
    wait_n(6);
    check("R7 pending fall ignored", 32'(taps), 32'h0);
    check("R5 osc_en after release", 32'(osc_en), 32'h1);

    // R3: rising edge alone does not count; R8 match in high phase
    cmp_val = '0;
    drive(1'b1, 5);
    check("R3 rise no count", 32'(taps), 32'h0);
    check("R8 match high phase", 32'(match), 32'h1);
    drive(1'b0, 5);
    check("R2 one fall", 32'(exp_cnt), 32'd1);
    check("R8 match low phase", 32'(match), 32'h0);

    // R1: 16 counted falls from zero set only stage 5
    do_reset(1'b0);
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, 3);
      drive(1'b0, 3);
    end
    check("R1 stage5 after 16", 32'(taps), 32'h2);

    // random phases with compare hits
    for (int k = 0; k < 400; k++) begin
      cmp_val = ($urandom % 3 == 0) ? W'(exp_cnt) : W'($urandom);
      drive(1'b1, 4 + ($urandom % 6));
      check_all("R2 random high");
      drive(1'b0, 4 + ($urandom % 6));
      check_all("R2 random low");
    end

    // reset released with oscillator high, then fall counts (R7)
    do_reset(1'b1);
    check("R7 high at release", 32'(taps), 32'h0);
    cmp_val = 14'd1;
    drive(1'b0, 5);
    drive(1'b1, 5);
    check("R7 post-release fall", 32'(exp_cnt), 32'd1);
    check_all("R8 after release");

    // R9 wrap
    do_reset(1'b0);
    cmp_val = '1;
    for (int k = 0; k < (1 << W) - 1; k++) begin
      drive(1'b1, 3);
      drive(1'b0, 3);
    end
    drive(1'b1, 4);
    check("R9 all ones", 32'(taps), 32'h3ff);
    check("R8 match at all ones", 32'(match), 32'h1);
    drive(1'b0, 4);
    check("R9 wrapped to zero", 32'(taps), 32'h0);
    check("R9 model zero", 32'(exp_cnt), 32'h0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule